// File: doc/BRIEF.md
# Dual-Path Storing Bus Transceiver

The block moves an 18-bit word between two bus sides, A and B, in both directions at once. Each direction has its own storage stage. That stage can pass its input straight through, keep its last word, or take a new word when its own strobe input goes from high to low. Every control input is sampled on one fast system clock, so the strobe is treated as data and its falling edge is found by comparing samples.

Each side has separate input, output and drive-enable signals in place of a three-state pin. The pad ring or the bus fabric turns these into real bus drivers. The A-to-B drive control is active high. The B-to-A drive control is active low, so one shared enable net can turn one direction on and the other off.

Top module: `bidir_store_xcvr`

## Requirements
- R1: The two directions are independent 18-bit paths. The A-to-B path uses `ab_transparent`, `ab_strobe` and `ab_drive`. The B-to-A path uses `ba_transparent`, `ba_strobe` and `ba_drive_n`. No control of one path affects the other.
- R2: While a path's transparent input is 1, its output equals its input in the same cycle. At the next clock edge the stored word takes that input.
- R3: While the transparent input is 0 and no strobe falling edge is seen, the stored word and the output do not change.
- R4: A strobe falling edge is a strobe sample of 1 on one system clock edge followed by a sample of 0 on the next. With the transparent input at 0, this edge loads the input present in the cycle where the strobe reads 0. The new word shows at the output from the following cycle.
- R5: `b_drv` is 1 exactly when `ab_drive` is 1 and reset is not asserted.
- R6: `a_drv` is 1 exactly when `ba_drive_n` is 0 and reset is not asserted.
- R7: When the transparent input falls, the output keeps the last passed word. This holds whether the strobe is steady high or has been low since before the fall. No falling edge is created by this sequence.
- R8: A synchronous active-high reset has three effects:
  - It clears both stored words to zero.
  - It holds `a_drv` and `b_drv` at 0 while asserted.
  - It sets both previous-strobe samples to 0, so a strobe that is high during reset and low in the first cycle after it does not cause a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Word received from side A |
| a_out | output | 18 | Word presented to side A (B-to-A path) |
| a_drv | output | 1 | Drive enable for side A |
| b_in | input | 18 | Word received from side B |
| b_out | output | 18 | Word presented to side B (A-to-B path) |
| b_drv | output | 1 | Drive enable for side B |
| ab_transparent | input | 1 | A-to-B pass-through select |
| ab_strobe | input | 1 | A-to-B load strobe; its falling edge loads |
| ab_drive | input | 1 | A-to-B drive request, active high |
| ba_transparent | input | 1 | B-to-A pass-through select |
| ba_strobe | input | 1 | B-to-A load strobe; its falling edge loads |
| ba_drive_n | input | 1 | B-to-A drive request, active low |

## Verification
The hardest cases to reach from the ports are the ones where the transparent input falls and a strobe falling edge must not be inferred. These are:
- the transparent input drops while the strobe is held high;
- the transparent input drops with the strobe already low;
- the strobe is high during reset and low right after it.

The vector table sets up each of these on purpose. A word sent with the transparent input high must then survive later changes of the input bus. A directed sequence around reset covers the last case. A long pseudo-random run then drives the two paths with different control bits and checks both against a bench model every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_PASS = 2'd1,
    ACT_LOAD = 2'd2
  } store_act_e;

  // A falling strobe edge: high on the previous sample, low now.
  function automatic logic strobe_fell(input logic prev_s, input logic now_s);
    return prev_s & ~now_s;
  endfunction

  // Storage action, by priority: pass-through, then edge load, then hold.
  function automatic store_act_e pick_act(input logic transp, input logic fall);
    if (transp)    return ACT_PASS;
    else if (fall) return ACT_LOAD;
    else           return ACT_HOLD;
  endfunction

  // Request polarity is normalised here; reset always wins.
  function automatic logic drive_on(input logic rst, input logic req,
                                    input logic active_low);
    logic asserted;
    asserted = active_low ? ~req : req;
    return ~rst & asserted;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic fall
);
  import xcvr_pkg::*;

  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign fall = strobe_fell(strobe_q, strobe);

  // R4: a detected edge means the strobe read high one cycle ago and low now
  p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
    fall |-> (!strobe && $past(strobe)));

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         transp,
  input  logic         fall,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  import xcvr_pkg::*;

  store_act_e act;
  assign act = pick_act(transp, fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (act)
        ACT_PASS, ACT_LOAD: q <= din;
        default:            q <= q;
      endcase
    end
  end

  // R2: every transparent cycle loads the storage
  p_track_r2: assert property (@(posedge clk) disable iff (rst)
    transp |=> (q == $past(din)));

  // R4: a falling strobe with the transparent input low loads the input word
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!transp && fall) |=> (q == $past(din)));

  // R3: neither pass-through nor edge means the storage is kept
  p_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (!transp && !fall) |=> $stable(q));

  // R8: reset clears the storage
  p_clear_r8: assert property (@(posedge clk)
    rst |=> (q == '0));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned W             = 18,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         transp,
  input  logic         strobe,
  input  logic         drive_req,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drv
);
  import xcvr_pkg::*;

  logic         fall;
  logic [W-1:0] held;

  xcvr_strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .fall   (fall)
  );

  xcvr_store #(.W(W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .transp (transp),
    .fall   (fall),
    .din    (din),
    .q      (held)
  );

  assign dout = transp ? din : held;

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign drv = drive_on(rst, drive_req, 1'b1);
    end else begin : g_oe_high
      assign drv = drive_on(rst, drive_req, 1'b0);
    end
  endgenerate

  // R3/R7: an opaque cycle with no edge leaves the next opaque output unchanged
  p_hold_out_r3: assert property (@(posedge clk) disable iff (rst)
    (!transp && $past(!transp) && !$past(fall) && !$past(rst))
      |-> $stable(dout));

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_drv,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_drv,
  input  logic              ab_transparent,
  input  logic              ab_strobe,
  input  logic              ab_drive,
  input  logic              ba_transparent,
  input  logic              ba_strobe,
  input  logic              ba_drive_n
);
  localparam int unsigned NPATH = 2;

  // Path 0 carries A to B, path 1 carries B to A.
  logic [NPATH-1:0]  transp_v, strobe_v, req_v, drv_v;
  logic [DATA_W-1:0] din_v  [NPATH];
  logic [DATA_W-1:0] dout_v [NPATH];

  assign transp_v = {ba_transparent, ab_transparent};
  assign strobe_v = {ba_strobe, ab_strobe};
  assign req_v    = {ba_drive_n, ab_drive};
  assign din_v[0] = a_in;
  assign din_v[1] = b_in;

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      xcvr_path #(
        .W             (DATA_W),
        .OE_ACTIVE_LOW (g == 1)
      ) u_path (
        .clk       (clk),
        .rst       (rst),
        .transp    (transp_v[g]),
        .strobe    (strobe_v[g]),
        .drive_req (req_v[g]),
        .din       (din_v[g]),
        .dout      (dout_v[g]),
        .drv       (drv_v[g])
      );
    end
  endgenerate

  assign b_out = dout_v[0];
  assign b_drv = drv_v[0];
  assign a_out = dout_v[1];
  assign a_drv = drv_v[1];

  // R8: no side is driven while reset is asserted
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |-> (!a_drv && !b_drv));

  // R1: a transparent B-to-A path shows B on A whatever the A-to-B controls do
  p_indep_r1: assert property (@(posedge clk) disable iff (rst)
    ba_transparent |-> (a_out == b_in));

endmodule

// File: tb/bidir_store_xcvr_bench.sv
module bidir_store_xcvr_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drv, b_drv;
  logic         ab_t, ab_s, ab_d, ba_t, ba_s, ba_dn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bidir_store_xcvr #(.DATA_W(W)) u_bidir_store_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_transparent(ab_t), .ab_strobe(ab_s), .ab_drive(ab_d),
    .ba_transparent(ba_t), .ba_strobe(ba_s), .ba_drive_n(ba_dn)
  );

  // Row: transparent, strobe, drive request (active high), data, expected output
  localparam int NV = 16;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 18'h01111, 18'h00000}, // after reset: cleared
    {1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA}, // R2 pass-through
    {1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA}, // R7 fall with strobe low
    {1'b0, 1'b1, 1'b1, 18'h00F0F, 18'h2AAAA}, // R3 rising strobe only
    {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h2AAAA}, // R3 steady high
    {1'b0, 1'b0, 1'b1, 18'h12345, 18'h2AAAA}, // R4 edge, loads now
    {1'b0, 1'b0, 1'b1, 18'h00001, 18'h12345}, // R4 loaded word visible
    {1'b0, 1'b1, 1'b0, 18'h0BEEF, 18'h12345}, // R5/R6 drive off
    {1'b1, 1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3}, // R2 with strobe high
    {1'b0, 1'b1, 1'b1, 18'h00000, 18'h3C3C3}, // R7 fall with strobe high
    {1'b0, 1'b0, 1'b1, 18'h2F0F0, 18'h3C3C3}, // R4 edge
    {1'b0, 1'b0, 1'b1, 18'h11111, 18'h2F0F0}, // R4 visible
    {1'b1, 1'b0, 1'b1, 18'h0A5A5, 18'h0A5A5}, // R2
    {1'b1, 1'b1, 1'b1, 18'h00001, 18'h00001}, // R2
    {1'b1, 1'b0, 1'b1, 18'h22222, 18'h22222}, // edge while transparent
    {1'b0, 1'b0, 1'b1, 18'h33333, 18'h22222}  // R3 keeps last pass
  };

  task automatic chk_word(input string tag, input logic [W-1:0] act,
                          input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] m_ab, m_ba;
    logic         p_ab, p_ba;
    logic [31:0]  r;

    rst = 1'b1; ab_t = 1'b0; ab_s = 1'b0; ab_d = 1'b1;
    ba_t = 1'b0; ba_s = 1'b0; ba_dn = 1'b0;
    a_in = '0; b_in = '0;
    repeat (2) @(negedge clk);
    #1;
    chk_bit("R8 reset b_drv", b_drv, 1'b0);
    chk_bit("R8 reset a_drv", a_drv, 1'b0);

    // Table walk: the same stimulus on both paths
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst  = 1'b0;
      ab_t = VEC[i][38]; ab_s = VEC[i][37]; ab_d = VEC[i][36];
      ba_t = VEC[i][38]; ba_s = VEC[i][37]; ba_dn = ~VEC[i][36];
      a_in = VEC[i][35:18]; b_in = VEC[i][35:18];
      #1;
      chk_word($sformatf("R2/R3/R4/R7 ab row %0d", i), b_out, VEC[i][17:0]);
      chk_word($sformatf("R2/R3/R4/R7 ba row %0d", i), a_out, VEC[i][17:0]);
      chk_bit ($sformatf("R5 row %0d", i), b_drv, VEC[i][36]);
      chk_bit ($sformatf("R6 row %0d", i), a_drv, VEC[i][36]);
    end

    // R8: reset mid-run with the strobe high, then a low strobe right after
    @(negedge clk);
    ab_t = 1'b1; ba_t = 1'b1; ab_s = 1'b1; ba_s = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    @(negedge clk);
    rst = 1'b1; ab_t = 1'b0; ba_t = 1'b0; ab_d = 1'b1; ba_dn = 1'b0;
    #1;
    chk_bit("R8 mid reset b_drv", b_drv, 1'b0);
    chk_bit("R8 mid reset a_drv", a_drv, 1'b0);
    @(negedge clk);
    rst = 1'b0; ab_s = 1'b0; ba_s = 1'b0;
    a_in = 18'h00155; b_in = 18'h00155;
    #1;
    chk_word("R8 cleared ab", b_out, 18'h0);
    chk_word("R8 cleared ba", a_out, 18'h0);
    chk_bit("R5 after reset", b_drv, 1'b1);
    chk_bit("R6 after reset", a_drv, 1'b1);
    @(negedge clk);
    #1;
    chk_word("R8 no edge from reset ab", b_out, 18'h0);
    chk_word("R8 no edge from reset ba", a_out, 18'h0);

    // R1: pseudo-random run, paths on separate control bits, bench model
    m_ab = '0; m_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
    r = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      @(negedge clk);
      ab_t = r[0] & r[1]; ab_s = r[2]; ab_d = r[3];
      ba_t = r[4] & r[5] & r[6]; ba_s = r[7]; ba_dn = r[8];
      a_in = r[26:9];
      b_in = {r[31:27], r[12:0]};
      #1;
      chk_word("R1 random ab", b_out, ab_t ? a_in : m_ab);
      chk_word("R1 random ba", a_out, ba_t ? b_in : m_ba);
      chk_bit ("R5 random", b_drv, ab_d);
      chk_bit ("R6 random", a_drv, ~ba_dn);
      if (ab_t || (p_ab && !ab_s)) m_ab = a_in;
      if (ba_t || (p_ba && !ba_s)) m_ba = b_in;
      p_ab = ab_s; p_ba = ba_s;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule